// File: doc/BRIEF.md
# Flash Target Reset and Discovery Sequencer

This block performs the power-up bring-up of a multi-target flash package. Leaving reset, it selects each chip-enable target in turn, starting at index 0. It sends the reset command to the selected target. It then waits out the busy period by repeating only read-status, and it treats the target as ready once the status byte shows the ready bit. When the target is ready, the block reads its identification bytes from address 00h. Each target is recorded as present or absent, and the ID bytes of each present target are kept.

All bus traffic goes through a byte-wide operation port to a separate bus sequencer, which handles pin timing. Each operation is a command byte, an address byte or a one-byte read, passed with a valid/ready handshake. Read data returns later on a separate strobe. A shared ready/busy input must also report ready before a target counts as reset complete. Busy and ID-read time limits are counted in clock cycles. When the last target has been handled, a done flag rises and all chip-enables stay high.

Top module: `flash_target_discovery`

## Requirements
- R1: While rst_n is low, all ce_n bits are high, present is all zero, init_done is low and op_valid is low. Bring-up starts by itself after reset is released.
- R2: Targets are handled in ascending index order. Exactly one ce_n bit is low while a target is handled. The first operation for each target is a command (op_kind 2'b00) with byte FFh.
- R3: From the accepted reset command until the target is seen ready, the only command byte issued is 70h. Each 70h is followed by one read operation (op_kind 2'b10).
- R4: A target is ready when a returned status byte has bit 6 set and tgt_ready is high in the same cycle as rd_valid. Either condition alone causes another status poll.
- R5: If the target is not ready within the busy limit (CLK_KHZ*BUSY_US/1000 cycles after the reset command is accepted), it is marked absent. No ID read is issued for it, and the block moves to the next target.
- R6: After the target is ready, the block issues command 90h, then an address operation (op_kind 2'b01) with byte 00h, then ID_BYTES reads, one at a time. The k-th byte returned is stored in id_table bits [(t*ID_BYTES+k)*8 +: 8] for target t.
- R7: A target is present only if all ID_BYTES bytes arrive and they are neither all FFh nor all 00h. For an absent target, present[t] is 0 and its id_table slot is zero.
- R8: If fewer than ID_BYTES ID bytes arrive within ID_LIMIT cycles of acceptance of the 90h command, the target is absent.
- R9: While op_valid is high and op_ready is low, op_valid, op_kind, op_byte and ce_n hold their values.
- R10: After the last target, init_done goes high and stays high. All ce_n bits are then high and no further operation is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | output | NUM_TGT | Active-low chip-enable per target |
| op_valid | output | 1 | Operation request to the bus sequencer |
| op_kind | output | 2 | 00 command, 01 address, 10 one-byte read |
| op_byte | output | 8 | Command or address byte |
| op_ready | input | 1 | Sequencer accepts the operation this cycle |
| rd_valid | input | 1 | Read data strobe from the sequencer |
| rd_data | input | 8 | Returned status or ID byte |
| tgt_ready | input | 1 | Shared ready/busy line, high when ready |
| present | output | NUM_TGT | Discovery result per target |
| id_table | output | NUM_TGT*ID_BYTES*8 | Stored ID bytes, per target |
| init_done | output | 1 | Bring-up finished |

## Verification
The hardest cases to reach are a target whose status byte already reports ready while the ready/busy line is still low, and a target that stops answering partway through its ID read. The bench handles both with a responder model. The model answers each accepted read according to a per-target profile: how many busy polls to give, how long the ready/busy line stays low, which ID bytes to return and how many. Stretching op_ready low on a fixed cadence also makes the block hold a request across several cycles.

// File: rtl/fdisc_pkg.sv
package fdisc_pkg;

   typedef enum logic [1:0] {
      OPK_CMD  = 2'd0,
      OPK_ADDR = 2'd1,
      OPK_READ = 2'd2
   } op_kind_e;

   localparam logic [7:0] OPC_RESET  = 8'hFF;
   localparam logic [7:0] OPC_STATUS = 8'h70;
   localparam logic [7:0] OPC_READID = 8'h90;
   localparam logic [7:0] ADR_ID     = 8'h00;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEL,
      ST_RST,
      ST_STCMD,
      ST_STRD,
      ST_STWAIT,
      ST_IDCMD,
      ST_IDADR,
      ST_IDRD,
      ST_IDWAIT,
      ST_REC,
      ST_DONE
   } dstate_e;

endpackage

// File: rtl/fdisc_timer.sv
module fdisc_timer #(
   parameter int unsigned BUSY_LIMIT = 250000,
   parameter int unsigned ID_LIMIT   = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_busy,
   input  logic restart_id,
   output logic expired
);
   localparam int unsigned MAX_LIM = (BUSY_LIMIT > ID_LIMIT) ? BUSY_LIMIT : ID_LIMIT;
   localparam int CNT_W = $clog2(MAX_LIM + 1);

   if (BUSY_LIMIT < 1 || ID_LIMIT < 1) begin : g_bad_limit
      $error("fdisc_timer: limits must be at least one cycle");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         limit_q <= CNT_W'(BUSY_LIMIT);
      end else if (restart_busy) begin
         cnt_q   <= '0;
         limit_q <= CNT_W'(BUSY_LIMIT);
      end else if (restart_id) begin
         cnt_q   <= '0;
         limit_q <= CNT_W'(ID_LIMIT);
      end else if (cnt_q < limit_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = (cnt_q >= limit_q);

endmodule

// File: rtl/fdisc_idcap.sv
module fdisc_idcap #(
   parameter int ID_BYTES     = 6,
   parameter bit REJECT_BLANK = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  push,
   input  logic [7:0]            din,
   output logic [ID_BYTES*8-1:0] id_flat,
   output logic                  id_ok
);
   localparam int CNT_W = $clog2(ID_BYTES + 1);

   if (ID_BYTES < 1) begin : g_bad_len
      $error("fdisc_idcap: ID_BYTES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             full;
   logic             blank;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (push && !full) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   for (genvar b = 0; b < ID_BYTES; b++) begin : g_byte
      logic [7:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (clear) begin
            slot_q <= '0;
         end else if (push && cnt_q == CNT_W'(b)) begin
            slot_q <= din;
         end
      end
      assign id_flat[b*8 +: 8] = slot_q;
   end

   if (REJECT_BLANK) begin : g_blank_chk
      assign blank = (&id_flat) || !(|id_flat);
   end else begin : g_blank_off
      assign blank = 1'b0;
   end

   assign full  = (cnt_q == CNT_W'(ID_BYTES));
   assign id_ok = full && !blank;

endmodule

// File: rtl/fdisc_fsm.sv
module fdisc_fsm
   import fdisc_pkg::*;
#(
   parameter int NUM_TGT  = 4,
   parameter int RDY_BIT  = 6,
   parameter int ID_BYTES = 6,
   localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
   localparam int IDN_W   = $clog2(ID_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_ready,
   input  logic             rd_valid,
   input  logic [7:0]       rd_data,
   input  logic             tgt_ready,
   input  logic             tmr_expired,
   input  logic             id_ok,
   output logic             op_valid,
   output op_kind_e         op_kind,
   output logic [7:0]       op_byte,
   output logic [TGT_W-1:0] tgt_idx,
   output logic             tgt_active,
   output logic             restart_busy,
   output logic             restart_id,
   output logic             id_clear,
   output logic             id_push,
   output logic             rec_we,
   output logic             rec_present,
   output logic             init_done
);
   dstate_e          state_q, state_d;
   logic [TGT_W-1:0] idx_q;
   logic [IDN_W-1:0] idn_q;
   logic             accept;
   logic             status_ok;
   logic             last_tgt;
   logic             last_byte;

   always_comb begin
      op_valid = 1'b0;
      op_kind  = OPK_CMD;
      op_byte  = 8'h00;
      case (state_q)
         ST_RST:   begin op_valid = 1'b1; op_byte = OPC_RESET;  end
         ST_STCMD: begin op_valid = 1'b1; op_byte = OPC_STATUS; end
         ST_STRD:  begin op_valid = 1'b1; op_kind = OPK_READ;   end
         ST_IDCMD: begin op_valid = 1'b1; op_byte = OPC_READID; end
         ST_IDADR: begin op_valid = 1'b1; op_kind = OPK_ADDR; op_byte = ADR_ID; end
         ST_IDRD:  begin op_valid = 1'b1; op_kind = OPK_READ;   end
         default:  ;
      endcase
   end

   assign accept       = op_valid && op_ready;
   assign status_ok    = rd_data[RDY_BIT] && tgt_ready;
   assign last_tgt     = (idx_q == TGT_W'(NUM_TGT - 1));
   assign last_byte    = (idn_q == IDN_W'(ID_BYTES - 1));
   assign tgt_active   = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign tgt_idx      = idx_q;
   assign restart_busy = (state_q == ST_RST) && accept;
   assign restart_id   = (state_q == ST_IDCMD) && accept;
   assign id_clear     = (state_q == ST_SEL);
   assign id_push      = (state_q == ST_IDWAIT) && rd_valid;
   assign rec_we       = (state_q == ST_REC);
   assign rec_present  = id_ok;
   assign init_done    = (state_q == ST_DONE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   state_d = ST_SEL;
         ST_SEL:    state_d = ST_RST;
         ST_RST:    if (accept) state_d = ST_STCMD;
         ST_STCMD:  if (accept) state_d = ST_STRD;
         ST_STRD:   if (accept) state_d = ST_STWAIT;
         ST_STWAIT: begin
            if (rd_valid) begin
               if (status_ok)        state_d = ST_IDCMD;
               else if (tmr_expired) state_d = ST_REC;
               else                  state_d = ST_STCMD;
            end else if (tmr_expired) begin
               state_d = ST_REC;
            end
         end
         ST_IDCMD:  if (accept) state_d = ST_IDADR;
         ST_IDADR:  if (accept) state_d = ST_IDRD;
         ST_IDRD:   if (accept) state_d = ST_IDWAIT;
         ST_IDWAIT: begin
            if (rd_valid)         state_d = last_byte ? ST_REC : ST_IDRD;
            else if (tmr_expired) state_d = ST_REC;
         end
         ST_REC:    state_d = last_tgt ? ST_DONE : ST_SEL;
         ST_DONE:   state_d = ST_DONE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         idn_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_REC && !last_tgt) idx_q <= idx_q + 1'b1;
         if (id_clear)     idn_q <= '0;
         else if (id_push) idn_q <= idn_q + 1'b1;
      end
   end

endmodule

// File: rtl/flash_target_discovery.sv
module flash_target_discovery
   import fdisc_pkg::*;
#(
   parameter int          NUM_TGT      = 4,
   parameter int          ID_BYTES     = 6,
   parameter int          RDY_BIT      = 6,
   parameter int unsigned CLK_KHZ      = 50000,
   parameter int unsigned BUSY_US      = 5000,
   parameter int unsigned ID_LIMIT     = 1024,
   parameter bit          REJECT_BLANK = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   output logic [NUM_TGT-1:0]            ce_n,
   output logic                          op_valid,
   output logic [1:0]                    op_kind,
   output logic [7:0]                    op_byte,
   input  logic                          op_ready,
   input  logic                          rd_valid,
   input  logic [7:0]                    rd_data,
   input  logic                          tgt_ready,
   output logic [NUM_TGT-1:0]            present,
   output logic [NUM_TGT*ID_BYTES*8-1:0] id_table,
   output logic                          init_done
);
   localparam int unsigned BUSY_LIMIT = (CLK_KHZ * BUSY_US) / 1000;
   localparam int          ID_W       = ID_BYTES * 8;
   localparam int          TGT_W      = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

   if (NUM_TGT < 1) begin : g_bad_tgt
      $error("flash_target_discovery: NUM_TGT must be at least 1");
   end
   if (RDY_BIT < 0 || RDY_BIT > 7) begin : g_bad_bit
      $error("flash_target_discovery: RDY_BIT must select a bit of a byte");
   end
   if (BUSY_LIMIT < 1) begin : g_bad_busy
      $error("flash_target_discovery: busy limit rounds to zero cycles");
   end

   op_kind_e         kind_w;
   logic [TGT_W-1:0] tgt_idx;
   logic             tgt_active;
   logic             restart_busy, restart_id, tmr_expired;
   logic             id_clear, id_push, id_ok;
   logic             rec_we, rec_present;
   logic [ID_W-1:0]  id_flat;

   fdisc_timer #(
      .BUSY_LIMIT (BUSY_LIMIT),
      .ID_LIMIT   (ID_LIMIT)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .restart_busy (restart_busy),
      .restart_id   (restart_id),
      .expired      (tmr_expired)
   );

   fdisc_idcap #(
      .ID_BYTES     (ID_BYTES),
      .REJECT_BLANK (REJECT_BLANK)
   ) u_idcap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (id_clear),
      .push    (id_push),
      .din     (rd_data),
      .id_flat (id_flat),
      .id_ok   (id_ok)
   );

   fdisc_fsm #(
      .NUM_TGT  (NUM_TGT),
      .RDY_BIT  (RDY_BIT),
      .ID_BYTES (ID_BYTES)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_ready     (op_ready),
      .rd_valid     (rd_valid),
      .rd_data      (rd_data),
      .tgt_ready    (tgt_ready),
      .tmr_expired  (tmr_expired),
      .id_ok        (id_ok),
      .op_valid     (op_valid),
      .op_kind      (kind_w),
      .op_byte      (op_byte),
      .tgt_idx      (tgt_idx),
      .tgt_active   (tgt_active),
      .restart_busy (restart_busy),
      .restart_id   (restart_id),
      .id_clear     (id_clear),
      .id_push      (id_push),
      .rec_we       (rec_we),
      .rec_present  (rec_present),
      .init_done    (init_done)
   );

   assign op_kind = kind_w;

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_slot
      logic            pres_q;
      logic [ID_W-1:0] id_q;
      logic            hit;

      assign hit = (tgt_idx == TGT_W'(t));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pres_q <= 1'b0;
            id_q   <= '0;
         end else if (rec_we && hit) begin
            pres_q <= rec_present;
            id_q   <= rec_present ? id_flat : '0;
         end
      end

      assign ce_n[t]                 = !(tgt_active && hit);
      assign present[t]              = pres_q;
      assign id_table[t*ID_W +: ID_W] = id_q;
   end

endmodule

// File: rtl/fdisc_chk.sv
module fdisc_chk #(
   parameter int NUM_TGT = 4,
   parameter int RDY_BIT = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_TGT-1:0] ce_n,
   input logic               op_valid,
   input logic [1:0]         op_kind,
   input logic [7:0]         op_byte,
   input logic               op_ready,
   input logic               rd_valid,
   input logic [7:0]         rd_data,
   input logic               tgt_ready,
   input logic [NUM_TGT-1:0] present,
   input logic               init_done
);
   logic               pend_q;
   logic [NUM_TGT-1:0] ce_q;
   logic [7:0]         last_cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         ce_q       <= '1;
         last_cmd_q <= 8'h00;
      end else begin
         ce_q <= ce_n;
         if (op_valid && op_ready && op_kind == 2'd0) last_cmd_q <= op_byte;
         if (ce_n != ce_q)
            pend_q <= 1'b0;
         else if (op_valid && op_ready && op_kind == 2'd0 && op_byte == 8'hFF)
            pend_q <= 1'b1;
         else if (rd_valid && last_cmd_q == 8'h70 && rd_data[RDY_BIT] && tgt_ready)
            pend_q <= 1'b0;
      end
   end

   AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ce_n) <= 1); // R2

   AST_OP_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> !(&ce_n)); // R2

   AST_BUSY_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && op_valid && op_kind == 2'd0) |-> op_byte == 8'h70); // R3

   AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_ready) |=> (op_valid && $stable(op_kind) && $stable(op_byte) && $stable(ce_n))); // R9

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (!op_valid && (&ce_n))); // R10

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done); // R10

   AST_PRESENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((present & $past(present)) == $past(present))); // R7

endmodule

bind flash_target_discovery fdisc_chk #(
   .NUM_TGT (NUM_TGT),
   .RDY_BIT (RDY_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .op_valid  (op_valid),
   .op_kind   (op_kind),
   .op_byte   (op_byte),
   .op_ready  (op_ready),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .tgt_ready (tgt_ready),
   .present   (present),
   .init_done (init_done)
);

// File: tb/tb_flash_target_discovery.sv
module tb_flash_target_discovery;
   localparam int NT = 6;
   localparam int NB = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NT-1:0]     ce_n;
   logic              op_valid;
   logic [1:0]        op_kind;
   logic [7:0]        op_byte;
   logic              op_ready = 1'b0;
   logic              rd_valid = 1'b0;
   logic [7:0]        rd_data = 8'h00;
   logic              tgt_ready = 1'b1;
   logic [NT-1:0]     present;
   logic [NT*NB*8-1:0] id_table;
   logic              init_done;

   always #10 clk = ~clk;

   flash_target_discovery #(
      .NUM_TGT (NT), .ID_BYTES (NB), .RDY_BIT (6),
      .CLK_KHZ (50000), .BUSY_US (4), .ID_LIMIT (100), .REJECT_BLANK (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .op_valid (op_valid),
      .op_kind (op_kind), .op_byte (op_byte), .op_ready (op_ready),
      .rd_valid (rd_valid), .rd_data (rd_data), .tgt_ready (tgt_ready),
      .present (present), .id_table (id_table), .init_done (init_done)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // per-target responder profile
   int busy_polls [NT] = '{2, -1, 1, 0, 0, 0};
   int rb_polls   [NT] = '{0,  0, 3, 0, 0, 0};
   int id_give    [NT] = '{6,  6, 6, 6, 3, 6};
   logic [7:0] idb [NT][NB] = '{
      '{8'h2C, 8'hA4, 8'h08, 8'h32, 8'hA1, 8'h00},
      '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66},
      '{8'hAD, 8'hDE, 8'h14, 8'hA7, 8'h42, 8'h4A},
      '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
      '{8'h98, 8'h3C, 8'h99, 8'hB3, 8'h7A, 8'hF2},
      '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}};
   logic [NT-1:0] exp_present = 6'b000101;

   typedef struct { int tgt; logic [1:0] kind; logic [7:0] byt; } exp_t;
   exp_t q[$];

   int  poll_cnt [NT];
   int  id_cnt   [NT];
   bit  rst_seen [NT];
   bit  idc_seen [NT];
   logic [7:0] last_cmd = 8'h00;
   int  rd_cnt = 0;
   logic [7:0] rd_val = 8'h00;
   logic rd_rb = 1'b1;
   bit  hold_pend = 1'b0;
   logic [1:0] hold_kind;
   logic [7:0] hold_byte;
   logic [NT-1:0] hold_ce;
   int  cyc = 0;
   bit  stop_mon = 1'b0;

   task automatic push_exp(input int t, input logic [1:0] k, input logic [7:0] b);
      exp_t e;
      e.tgt = t; e.kind = k; e.byt = b;
      q.push_back(e);
   endtask

   // driver: expected non-poll operations per target
   task automatic drive_target(input int t);
      push_exp(t, 2'd0, 8'hFF);
      if (busy_polls[t] >= 0) begin
         push_exp(t, 2'd0, 8'h90);
         push_exp(t, 2'd1, 8'h00);
         for (int k = 0; k < ((id_give[t] < NB) ? id_give[t] + 1 : NB); k++)
            push_exp(t, 2'd2, 8'h00);
      end
   endtask

   // monitor and responder, acting between clock edges
   always @(negedge clk) begin
      if (rst_n && !stop_mon) begin
         cyc++;
         rd_valid = 1'b0;
         if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
               rd_valid  = 1'b1;
               rd_data   = rd_val;
               tgt_ready = rd_rb;
            end
         end
         if (hold_pend) begin
            chk(op_valid && op_kind == hold_kind && op_byte == hold_byte && ce_n == hold_ce,
                "R9", "request held while stalled", {op_valid, op_kind, op_byte},
                {1'b1, hold_kind, hold_byte});
            hold_pend = 1'b0;
         end
         op_ready = (cyc % 3 != 2);
         if (op_valid) begin
            if (!op_ready) begin
               hold_pend = 1'b1; hold_kind = op_kind; hold_byte = op_byte; hold_ce = ce_n;
            end else begin
               int t;
               int lows;
               t = -1; lows = 0;
               for (int i = 0; i < NT; i++) if (!ce_n[i]) begin t = i; lows++; end
               chk(lows == 1, "R2", "one chip-enable low per operation", lows, 1);
               if (t >= 0) begin
                  if (op_kind == 2'd0 && op_byte == 8'h70) begin
                     chk(rst_seen[t] && !idc_seen[t], "R3", "status only while busy", t, t);
                     last_cmd = 8'h70;
                  end else if (op_kind == 2'd2 && last_cmd == 8'h70) begin
                     int p;
                     p = poll_cnt[t];
                     rd_val = (busy_polls[t] < 0 || p < busy_polls[t]) ? 8'h80 : 8'hE0;
                     rd_rb  = (p >= rb_polls[t]);
                     poll_cnt[t]++;
                     rd_cnt = 2;
                  end else begin
                     exp_t e;
                     if (q.size() == 0) begin
                        chk(1'b0, "R2", "unexpected operation", {op_kind, op_byte}, 0);
                     end else begin
                        e = q.pop_front();
                        chk(e.tgt == t && e.kind == op_kind && (op_kind == 2'd2 || e.byt == op_byte),
                            (op_kind == 2'd0 && op_byte == 8'hFF) ? "R2" : "R6",
                            "operation order", {t[7:0], 6'd0, op_kind, op_byte},
                            {e.tgt[7:0], 6'd0, e.kind, e.byt});
                     end
                     if (op_kind == 2'd0) begin
                        last_cmd = op_byte;
                        if (op_byte == 8'hFF) rst_seen[t] = 1'b1;
                        if (op_byte == 8'h90) idc_seen[t] = 1'b1;
                     end
                     if (op_kind == 2'd2) begin
                        if (id_cnt[t] < id_give[t]) begin
                           rd_val = idb[t][id_cnt[t]];
                           rd_rb  = 1'b1;
                           rd_cnt = 2;
                        end
                        id_cnt[t]++;
                     end
                  end
               end
            end
         end
      end
   end

   initial begin
      int wd;
      for (int t = 0; t < NT; t++) drive_target(t);
      repeat (4) @(negedge clk);
      chk(&ce_n, "R1", "chip-enables high in reset", ce_n, '1);
      chk(present == '0, "R1", "present clear in reset", present, 0);
      chk(!init_done && !op_valid, "R1", "done and request low in reset",
          {init_done, op_valid}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      wd = 0;
      while (!init_done && wd < 20000) begin
         @(posedge clk);
         wd++;
      end
      chk(wd < 20000, "R10", "watchdog before done", wd, 0);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk(init_done && !op_valid && (&ce_n), "R10", "quiet after done",
             {init_done, op_valid, ce_n}, {1'b1, 1'b0, {NT{1'b1}}});
      end
      stop_mon = 1'b1;
      chk(q.size() == 0, "R2", "all expected operations seen", q.size(), 0);
      chk(poll_cnt[0] == 3, "R4", "polls until status ready", poll_cnt[0], 3);
      chk(poll_cnt[2] == 4, "R4", "status ready but line busy keeps polling", poll_cnt[2], 4);
      chk(poll_cnt[3] == 1, "R4", "immediate ready", poll_cnt[3], 1);
      chk(poll_cnt[1] > 3 && !idc_seen[1], "R5", "busy timeout without ID read",
          poll_cnt[1], 4);
      chk(present[1] == 1'b0, "R5", "timed-out target absent", present[1], 0);
      chk(present[4] == 1'b0 && id_cnt[4] == 4, "R8", "short ID target absent",
          {present[4], id_cnt[4][7:0]}, {1'b0, 8'd4});
      chk(present[3] == 1'b0, "R7", "all-FF ID absent", present[3], 0);
      chk(present[5] == 1'b0, "R7", "all-00 ID absent", present[5], 0);
      chk(present == exp_present, "R7", "presence map", present, exp_present);
      for (int t = 0; t < NT; t++) begin
         logic [NB*8-1:0] e;
         for (int b = 0; b < NB; b++) e[b*8 +: 8] = exp_present[t] ? idb[t][b] : 8'h00;
         chk(id_table[t*NB*8 +: NB*8] == e, exp_present[t] ? "R6" : "R7",
             "stored ID slot", id_table[t*NB*8 +: NB*8], e);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule